// File: doc/BRIEF.md
# Per-processor interrupt request interface

This block sits between an interrupt distributor and one processor. The distributor presents its best pending candidate as an interrupt ID, a priority and a valid flag. The block compares that candidate against a software-programmed priority threshold and against the priority of the interrupts the processor is already servicing. When all of the checks pass and signalling is enabled, it raises the processor's interrupt request line.

The processor uses a small register port. Reading the acknowledge register claims the current candidate. The read returns its ID, pushes the candidate onto an internal stack of active interrupts, and pulses an acknowledge strobe with the ID back to the distributor. When no candidate qualifies, the read returns the spurious ID 1023 and changes nothing.

Writing the ID to the completion register retires the most recently acknowledged interrupt. This restores the running priority of the interrupt that was active before it, so nested servicing is supported up to a parameterised depth.

Top module: `cpu_irq_iface`

Register map. The address is 2 bits, and data is 32 bits on writes and on reads:

| Address | Register | Access |
|---|---|---|
| 0 | control | bit 0 enables signalling |
| 1 | priority threshold | 8 bits |
| 2 | acknowledge | read only; writes have no effect |
| 3 | completion | write only; reads return 0 |

Read data and `rvalid_o` appear one clock after the request cycle.

## Requirements
- R1: After reset, control reads 0, the threshold reads 0x00, `irq_o` is low even for a priority-0 candidate, and an acknowledge read returns 1023.
- R2: While control bit 0 is 0, `irq_o` stays low and an acknowledge read returns 1023.
- R3: A candidate is signalled only if its priority is numerically strictly lower than the threshold. A priority equal to the threshold is not signalled.
- R4: An acknowledge read of a qualifying candidate returns its ID in bits 9:0, with bits 31:10 zero, one clock after the request. In that same cycle `ack_o` pulses high with `ack_id_o` equal to the ID. IDs 0 to 31 are acknowledged like any other ID.
- R5: An acknowledge read with no qualifying candidate returns 1023. It does not pulse `ack_o` and does not change the set of active interrupts.
- R6: While an interrupt is active, a candidate is signalled only if its priority is strictly lower numerically than that of the most recently acknowledged active interrupt.
- R7: Writing the ID of the most recently acknowledged active interrupt to the completion register retires it. The running priority returns to that of the previous active interrupt, or to idle when no interrupt remains active.
- R8: A completion write is ignored when its ID is not the most recently acknowledged active interrupt, or when data bits 31:10 are not all zero.
- R9: Candidates with IDs above 1020 are never signalled, and acknowledging one returns 1023.
- R10: Up to DEPTH interrupts may be active at once. With DEPTH active, `irq_o` stays low and acknowledge reads return 1023.
- R11: Reads of control and threshold return the stored values, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cand_valid_i | input | 1 | Distributor has a pending candidate |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_prio_i | input | PRIO_W | Candidate priority, lower value is more urgent |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_o | output | 1 | Acknowledge strobe to the distributor |
| ack_id_o | output | 10 | ID acknowledged with ack_o |

## Verification
The bench builds the block with DEPTH set to 2 and PRIO_W left at 8. The shallow stack lets two nested acknowledges reach the full-stack boundary. With the stack full, the bench checks that even a priority-0 candidate is held off. It also checks that an out-of-order completion leaves the inner running priority in force, and that retiring both levels unwinds the running priority back to idle.

// File: rtl/cif_pkg.sv
package cif_pkg;
  localparam int unsigned ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam logic [ID_W-1:0] MAX_VALID_ID = 10'd1020;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_ACK   = 2'd2,
    REG_EOI   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cif_prio_filter.sv
module cif_prio_filter
  import cif_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0] pmask_i,
  input  logic [PRIO_W:0]   run_prio_i,
  input  logic              room_i,
  output logic              pass_o
);
  logic id_ok, below_mask, above_run;

  assign id_ok      = (id_i <= MAX_VALID_ID);
  assign below_mask = (prio_i < pmask_i);
  assign above_run  = ({1'b0, prio_i} < run_prio_i);
  assign pass_o     = en_i & valid_i & id_ok & below_mask & above_run & room_i;
endmodule

// File: rtl/cif_active_stack.sv
module cif_active_stack
  import cif_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned PRIO_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ID_W-1:0]   push_id_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [ID_W-1:0]   top_id_o,
  output logic [PRIO_W:0]   run_prio_o,
  output logic [CNT_W-1:0]  depth_o
);
  logic [ID_W-1:0]   id_q [DEPTH];
  logic [PRIO_W-1:0] pr_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign top_id_o   = id_q[0];
  assign run_prio_o = empty_o ? {1'b1, {PRIO_W{1'b0}}} : {1'b0, pr_q[0]};
  assign depth_o    = cnt_q;

  // entry 0 is the most recently acknowledged interrupt
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [ID_W-1:0]   id_below;
    logic [PRIO_W-1:0] pr_below;
    if (i == DEPTH - 1) begin : g_last
      assign id_below = '0;
      assign pr_below = '0;
    end else begin : g_mid
      assign id_below = id_q[i+1];
      assign pr_below = pr_q[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_q[i] <= '0;
        pr_q[i] <= '0;
      end else if (push_i) begin
        if (i == 0) begin
          id_q[i] <= push_id_i;
          pr_q[i] <= push_prio_i;
        end else begin
          id_q[i] <= id_q[(i == 0) ? 0 : i-1];
          pr_q[i] <= pr_q[(i == 0) ? 0 : i-1];
        end
      end else if (pop_i) begin
        id_q[i] <= id_below;
        pr_q[i] <= pr_below;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (push_i) cnt_q <= cnt_q + 1'b1;
    else if (pop_i)  cnt_q <= cnt_q - 1'b1;
  end

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_single_op_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cif_pkg::*;
#(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned DATA_W = 32,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              irq_o,
  output logic              ack_o,
  output logic [ID_W-1:0]   ack_id_o
);
  logic              en_q;
  logic [PRIO_W-1:0] pmask_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, ack_q;
  logic [ID_W-1:0]   ack_id_q;

  logic              pass, full, empty;
  logic [ID_W-1:0]   top_id;
  logic [PRIO_W:0]   run_prio;
  logic [CNT_W-1:0]  depth;
  logic              rd, wr, rd_ack, push, pop;
  reg_addr_e         addr;

  assign addr   = reg_addr_e'(addr_i);
  assign rd     = req_i & ~we_i;
  assign wr     = req_i & we_i;
  assign rd_ack = rd & (addr == REG_ACK);
  assign push   = rd_ack & pass;
  assign pop    = wr & (addr == REG_EOI) & ~empty
                & (wdata_i[DATA_W-1:ID_W] == '0) & (wdata_i[ID_W-1:0] == top_id);

  cif_prio_filter #(.PRIO_W(PRIO_W)) u_filter (
    .en_i      (en_q),
    .valid_i   (cand_valid_i),
    .id_i      (cand_id_i),
    .prio_i    (cand_prio_i),
    .pmask_i   (pmask_q),
    .run_prio_i(run_prio),
    .room_i    (~full),
    .pass_o    (pass)
  );

  cif_active_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_id_i  (cand_id_i),
    .push_prio_i(cand_prio_i),
    .pop_i      (pop),
    .full_o     (full),
    .empty_o    (empty),
    .top_id_o   (top_id),
    .run_prio_o (run_prio),
    .depth_o    (depth)
  );

  always_comb begin
    rdata_d = '0;
    unique case (addr)
      REG_CTRL:  rdata_d = DATA_W'(en_q);
      REG_PMASK: rdata_d = DATA_W'(pmask_q);
      REG_ACK:   rdata_d = DATA_W'(pass ? cand_id_i : SPURIOUS_ID);
      REG_EOI:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      pmask_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      ack_q    <= 1'b0;
      ack_id_q <= '0;
    end else begin
      rvalid_q <= rd;
      ack_q    <= push;
      if (rd)   rdata_q  <= rdata_d;
      if (push) ack_id_q <= cand_id_i;
      if (wr && addr == REG_CTRL)  en_q    <= wdata_i[0];
      if (wr && addr == REG_PMASK) pmask_q <= wdata_i[PRIO_W-1:0];
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_o    = pass;
  assign ack_o    = ack_q;
  assign ack_id_o = ack_id_q;

  assert_irq_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !irq_o);
  assert_irq_below_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cand_prio_i < pmask_q));
  assert_ack_id_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (rvalid_o && rdata_o == DATA_W'(ack_id_o)));
  assert_spurious_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack && !irq_o) |=> (depth == $past(depth) && !ack_o));
  assert_irq_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cand_id_i <= MAX_VALID_ID));
  assert_full_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth == CNT_W'(DEPTH)) |-> !irq_o);
endmodule

// File: tb/sim_cpu_irq_iface.sv
module sim_cpu_irq_iface;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq, ack;
  logic [9:0]  ack_id;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] data;
    bit          ack;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  cpu_irq_iface #(.PRIO_W(8), .DEPTH(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cand_valid_i(cand_valid), .cand_id_i(cand_id), .cand_prio_i(cand_prio),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq),
    .ack_o(ack), .ack_id_o(ack_id)
  );

  // monitor: compares read responses against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      tests++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL unexpected read response: got %h expected none", rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rdata !== e.data || ack !== e.ack || (e.ack && ack_id !== e.data[9:0])) begin
          fails++;
          $display("FAIL %s: rdata=%h ack=%b ack_id=%0d expected rdata=%h ack=%b",
                   e.tag, rdata, ack, ack_id, e.data, e.ack);
        end
      end
    end
  end

  task automatic cpu_read(input logic [1:0] a, input logic [31:0] exp, input bit exp_ack,
                          input string tag);
    exp_t e;
    e.data = exp; e.ack = exp_ack; e.tag = tag;
    @(negedge clk);
    sb.push_back(e);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic set_cand(input bit v, input logic [9:0] id, input logic [7:0] p);
    @(negedge clk);
    cand_valid = v; cand_id = id; cand_prio = p;
  endtask

  task automatic chk_irq(input bit exp, input string tag);
    #2;
    tests++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq=%b expected %b", tag, irq, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cpu_read(2'd0, 32'h0, 0, "R1 ctrl after reset");
    cpu_read(2'd1, 32'h0, 0, "R1 threshold after reset");
    set_cand(1, 10'd40, 8'h00);
    chk_irq(0, "R1 irq low after reset");
    cpu_read(2'd2, 32'h3FF, 0, "R1 ack spurious after reset");

    // R2 disabled interface
    cpu_write(2'd1, 32'hF0);
    set_cand(1, 10'd40, 8'hA0);
    chk_irq(0, "R2 irq low while disabled");
    cpu_read(2'd2, 32'h3FF, 0, "R2 ack spurious while disabled");

    cpu_write(2'd0, 32'h1);
    chk_irq(1, "R3 candidate below threshold signalled");
    cpu_read(2'd0, 32'h1, 0, "R11 ctrl readback");
    cpu_read(2'd1, 32'hF0, 0, "R11 threshold readback");

    // R3 boundary
    set_cand(1, 10'd40, 8'hF0);
    chk_irq(0, "R3 priority equal to threshold");
    set_cand(1, 10'd40, 8'hEF);
    chk_irq(1, "R3 priority one below threshold");

    // R9 reserved IDs
    set_cand(1, 10'd1021, 8'h10);
    chk_irq(0, "R9 id 1021 not signalled");
    cpu_read(2'd2, 32'h3FF, 0, "R9 ack of id 1021 spurious");
    set_cand(1, 10'd1020, 8'h10);
    chk_irq(1, "R9 id 1020 signalled");

    // R4 acknowledge, R6 running priority
    set_cand(1, 10'd40, 8'hA0);
    cpu_read(2'd2, 32'd40, 1, "R4 ack returns id 40");
    chk_irq(0, "R6 equal priority held off while active");
    set_cand(1, 10'd50, 8'hA0);
    cpu_read(2'd2, 32'h3FF, 0, "R5 spurious while held off");
    set_cand(1, 10'd35, 8'h90);
    chk_irq(1, "R6 higher priority preempts / R5 no state change");
    cpu_read(2'd2, 32'd35, 1, "R4 nested ack returns id 35");

    // R10 full stack
    set_cand(1, 10'd36, 8'h00);
    chk_irq(0, "R10 full stack holds off priority 0");
    cpu_read(2'd2, 32'h3FF, 0, "R10 ack spurious when full");

    // R8 ignored completions
    cpu_write(2'd3, 32'd40);
    set_cand(1, 10'd37, 8'h95);
    chk_irq(0, "R8 out-of-order completion ignored");
    cpu_write(2'd3, 32'h0000_0400 | 32'd35);
    chk_irq(0, "R8 completion with upper bits set ignored");

    // R7 completion unwinds
    cpu_write(2'd3, 32'd35);
    chk_irq(1, "R7 completion restores outer running priority");
    set_cand(1, 10'd37, 8'hA5);
    chk_irq(0, "R7 outer interrupt still active");
    cpu_write(2'd3, 32'd40);
    chk_irq(1, "R7 completion returns to idle");

    // R4 private-range ID
    set_cand(1, 10'd5, 8'h10);
    cpu_read(2'd2, 32'd5, 1, "R4 ack of private id 5");
    cpu_write(2'd3, 32'd5);
    set_cand(1, 10'd6, 8'h20);
    chk_irq(1, "R7 idle after private completion");

    // R2 disable again
    cpu_write(2'd0, 32'h0);
    chk_irq(0, "R2 irq drops when disabled");

    repeat (3) @(negedge clk);
    tests++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R4 missing read responses: got %0d pending expected 0", sb.size());
    end
    finish_run();
  end
endmodule